// File: doc/BRIEF.md
# Double-to-Single Precision Converter

This block narrows an IEEE-754 binary64 operand to binary32 in one registered step. A sample is taken whenever the input strobe is high. The result word and three exception flags appear on the output registers one clock later, together with an output strobe. Two rounding behaviours are selectable on every sample: round to nearest with ties to even, or truncation toward zero.

The datapath has two stages. The first stage keeps the top 30 fraction bits and folds every discarded bit into a sticky LSB. It then inserts the hidden bit and moves the exponent into the single-precision range. The second stage is a generic binary32 round-and-pack unit with 7 guard bits. It handles overflow, and gradual underflow into the subnormal range. Infinity and NaN inputs take no special path. An all-ones exponent is far above the single-precision range, so it goes through the ordinary overflow handling like any other large value.

Top module: `dbl_to_sgl_cvt`

## Requirements
- R1: After reset and before the first sample, out_valid, out_data and all three flags are 0.
- R2: Bit 31 of the result always equals bit 63 of the sampled operand. This holds for zero, overflowed and underflowed results too.
- R3: An operand with exponent field (bits 62:52) and fraction field (bits 51:0) both zero gives a signed zero with no flag raised.
- R4: A binary64 value that is exactly representable as a normal binary32 value converts exactly, with no flag. The exponent is re-biased from 1023 to 127, and the top 23 fraction bits move to result bits 22:0. Example: 0x3FF0000000000000 gives 0x3F800000.
- R5: With rnd_trunc = 0, the result is rounded to nearest with ties to even. Every discarded fraction bit counts toward the decision. out_inx is 1 exactly when any discarded bit was non-zero.
- R6: With rnd_trunc = 1, discarded bits are dropped and the magnitude is never increased. out_inx is 1 when any of them was non-zero.
- R7: With rnd_trunc = 0, a value at or above 2^128 after rounding gives infinity (exponent field 0xFF, fraction 0) with out_ovf = 1 and out_inx = 1. This includes operands whose exponent field is 0x7FF.
- R8: With rnd_trunc = 1, a value at or above 2^128 before rounding gives the largest finite magnitude 0x7F7FFFFF with the operand's sign, and out_ovf = 1, out_inx = 1. Truncation never produces exponent field 0xFF.
- R9: A value between the largest finite binary32 and 2^128 gives infinity with out_ovf = 1 when rounding to nearest carries upward. Under truncation, the same value gives 0x7F7FFFFF with only out_inx = 1.
- R10: A value below 2^-126 is denormalised into the subnormal range (exponent field 0) and then rounded at a quantum of 2^-149. out_unf is 1 only when the result is inexact and the value is tiny. Tiny means that rounding to 24 significant bits with an unbounded exponent stays below 2^-126.
- R11: out_valid is in_valid delayed by one cycle. While in_valid is 0, out_data and the flags keep their previous values whatever in_data and rnd_trunc do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Sample strobe for in_data and rnd_trunc |
| in_data | input | 64 | binary64 operand |
| rnd_trunc | input | 1 | 0 = round to nearest even, 1 = truncate toward zero |
| out_valid | output | 1 | High one cycle after a sample |
| out_data | output | 32 | binary32 result |
| out_ovf | output | 1 | Overflow flag |
| out_unf | output | 1 | Underflow flag |
| out_inx | output | 1 | Inexact flag |

## Verification
The sweep covers every one of the 2048 input exponents. For each exponent it uses fraction patterns that put an exact tie, a tie with an odd kept bit, a lone sticky bit or an all-ones tail at the exact bit where the rounding decision falls. It does this both in the normal range and at each subnormal shift. A design that loses the sticky bit of the 22 narrowed bits, or of the denormalising shift, would round a tie-plus-epsilon down or report a pure tie as exact. A design with the wrong tininess rule would raise out_unf for a value just under 2^-126 that rounds up to the smallest normal. A wrong overflow boundary would show as a missing carry into infinity above the largest finite value, or as infinity appearing under truncation.

// File: rtl/dcv_pkg.sv
package dcv_pkg;
    localparam int DW      = 64;
    localparam int SW      = 32;
    localparam int DEXP    = 11;
    localparam int DFRAC   = 52;
    localparam int SEXP    = 8;
    localparam int SFRAC   = 23;
    localparam int GUARD   = 7;
    localparam int WSIG    = SFRAC + GUARD;
    localparam int NARROW  = DFRAC - WSIG;
    localparam int EW      = 13;
    localparam int BIAS_ADJ = ((1 << (DEXP - 1)) - 1) - ((1 << (SEXP - 1)) - 1) + 1;
    localparam int HALF    = 1 << (GUARD - 1);
    localparam int EXP_LIM = (1 << SEXP) - 3;

    typedef struct packed {
        logic                 sign;
        logic signed [EW-1:0] exp;
        logic [SW-1:0]        sig;
    } unpk_t;

    typedef struct packed {
        logic [SW-1:0] data;
        logic          ovf;
        logic          unf;
        logic          inx;
    } res_t;

    // right shift that ORs every bit shifted out into the LSB
    function automatic logic [SW-1:0] jam_shr(input logic [SW-1:0] a,
                                              input logic [EW-1:0] cnt);
        logic [SW-1:0] mask;
        if (cnt >= EW'(SW)) begin
            return {{(SW-1){1'b0}}, |a};
        end
        mask = (SW'(1) << cnt) - SW'(1);
        return (a >> cnt) | {{(SW-1){1'b0}}, |(a & mask)};
    endfunction
endpackage

// File: rtl/dcv_narrow.sv
module dcv_narrow
    import dcv_pkg::*;
(
    input  logic [DW-1:0] din_i,
    output unpk_t         unpk_o
);
    logic [DEXP-1:0]  exp_in;
    logic [DFRAC-1:0] frac_in;
    logic [WSIG-1:0]  sig_n;
    logic             nz;

    always_comb begin
        exp_in   = din_i[DW-2 -: DEXP];
        frac_in  = din_i[DFRAC-1:0];
        sig_n    = frac_in[DFRAC-1 -: WSIG];
        sig_n[0] = sig_n[0] | (|frac_in[NARROW-1:0]);
        nz       = (exp_in != '0) || (sig_n != '0);

        unpk_o.sign = din_i[DW-1];
        if (nz) begin
            unpk_o.exp = $signed({{(EW-DEXP){1'b0}}, exp_in}) - $signed(EW'(BIAS_ADJ));
            unpk_o.sig = (SW'(1) << WSIG) | SW'(sig_n);
        end else begin
            unpk_o.exp = '0;
            unpk_o.sig = '0;
        end
    end
endmodule

// File: rtl/dcv_round.sv
module dcv_round
    import dcv_pkg::*;
(
    input  unpk_t unpk_i,
    input  logic  trunc_i,
    output res_t  res_o
);
    logic [SW-1:0]        inc, pre_sum, sig_a, sum_a, qsig, packed_v;
    logic [GUARD-1:0]     rbits;
    logic signed [EW-1:0] exp_a;
    logic                 big, under, tiny;

    always_comb begin
        inc     = trunc_i ? '0 : SW'(HALF);
        pre_sum = unpk_i.sig + inc;
        big     = (unpk_i.exp > $signed(EW'(EXP_LIM))) ||
                  ((unpk_i.exp == $signed(EW'(EXP_LIM))) && pre_sum[SW-1]);
        under   = unpk_i.exp < 0;
        tiny    = (unpk_i.exp < -1) || !pre_sum[SW-1];

        if (under) begin
            sig_a = jam_shr(unpk_i.sig, EW'(-unpk_i.exp));
            exp_a = '0;
        end else begin
            sig_a = unpk_i.sig;
            exp_a = unpk_i.exp;
        end

        rbits = sig_a[GUARD-1:0];
        sum_a = sig_a + inc;
        qsig  = sum_a >> GUARD;
        if (!trunc_i && (rbits == GUARD'(HALF))) begin
            qsig[0] = 1'b0;
        end
        if (qsig == '0) begin
            exp_a = '0;
        end
        packed_v = {unpk_i.sign, {(SW-1){1'b0}}}
                 + (SW'(exp_a[SEXP-1:0]) << SFRAC) + qsig;

        res_o.ovf  = big;
        res_o.inx  = big || (rbits != '0);
        res_o.unf  = !big && under && tiny && (rbits != '0);
        res_o.data = big ? ({unpk_i.sign, {SEXP{1'b1}}, {SFRAC{1'b0}}} - SW'(trunc_i))
                         : packed_v;
    end

    // a denormalised operand never lands above the smallest normal exponent
    always_comb begin
        if (under) begin
            p_subn_field_r10: assert (packed_v[SW-2 -: SEXP] <= SEXP'(1));
        end
    end
endmodule

// File: rtl/dbl_to_sgl_cvt.sv
module dbl_to_sgl_cvt
    import dcv_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [DW-1:0] in_data,
    input  logic          rnd_trunc,
    output logic          out_valid,
    output logic [SW-1:0] out_data,
    output logic          out_ovf,
    output logic          out_unf,
    output logic          out_inx
);
    typedef struct packed {
        logic valid;
        res_t res;
    } state_t;

    unpk_t  unpk;
    res_t   rnd_res;
    state_t st_d, st_q;

    dcv_narrow u_narrow (
        .din_i  (in_data),
        .unpk_o (unpk)
    );

    dcv_round u_round (
        .unpk_i  (unpk),
        .trunc_i (rnd_trunc),
        .res_o   (rnd_res)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.res = rnd_res;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.valid;
    assign out_data  = st_q.res.data;
    assign out_ovf   = st_q.res.ovf;
    assign out_unf   = st_q.res.unf;
    assign out_inx   = st_q.res.inx;

    p_valid_lag_r11: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_valid_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_data) && $stable(out_ovf) &&
                       $stable(out_unf) && $stable(out_inx)));
    p_sign_copy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_data[SW-1] == $past(in_data[DW-1])));
    p_ovf_inexact_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_ovf |-> out_inx);
    p_unf_inexact_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_unf |-> out_inx);
    p_trunc_no_inf_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && rnd_trunc) |=> (out_data[SW-2 -: SEXP] != '1));
    p_inf_iff_ovf_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !rnd_trunc) |=> ((out_data[SW-2 -: SEXP] == '1) == out_ovf));
endmodule

// File: tb/dbl_to_sgl_cvt_tb.sv
`timescale 1ns/1ps
module dbl_to_sgl_cvt_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] in_data = '0;
    logic        rnd_trunc = 1'b0;
    logic        out_valid;
    logic [31:0] out_data;
    logic        out_ovf, out_unf, out_inx;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    dbl_to_sgl_cvt u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .rnd_trunc (rnd_trunc),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_ovf   (out_ovf),
        .out_unf   (out_unf),
        .out_inx   (out_inx)
    );

    // result packed as {valid, data, ovf, unf, inx}
    task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic convert(input logic [63:0] d, input logic tr, output logic [35:0] got);
        @(negedge clk);
        in_valid  = 1'b1;
        in_data   = d;
        rnd_trunc = tr;
        @(negedge clk);
        in_valid  = 1'b0;
        got = {out_valid, out_data, out_ovf, out_unf, out_inx};
    endtask

    // value = 1.f * 2^(e-1023), quantised to binary32 from first principles
    function automatic logic [34:0] model(input logic [63:0] d, input logic tr);
        logic        s;
        int          e, ue, te, sh;
        logic [63:0] m, kept, rem, half;
        logic        up, inx, tiny;
        logic [31:0] res;
        int          fld;
        s = d[63];
        e = int'(d[62:52]);
        if (e == 0 && d[51:0] == 0) return {s, 31'b0, 3'b000};
        m  = {11'b0, 1'b1, d[51:0]};
        ue = e - 1023;
        tiny = 1'b0;
        if (ue < -126) begin
            kept = m >> 29;
            rem  = m & ((64'd1 << 29) - 1);
            half = 64'd1 << 28;
            up   = !tr && (rem > half || (rem == half && kept[0]));
            tiny = !((ue == -127) && (kept + 64'(up) == (64'd1 << 24)));
        end
        te = (ue < -126) ? -126 : ue;
        sh = 29 + (te - ue);
        if (sh >= 60) begin
            kept = 0; up = 1'b0; inx = 1'b1;
        end else begin
            kept = m >> sh;
            rem  = m & ((64'd1 << sh) - 1);
            half = 64'd1 << (sh - 1);
            inx  = (rem != 0);
            up   = !tr && (rem > half || (rem == half && kept[0]));
        end
        kept = kept + 64'(up);
        if (kept == (64'd1 << 24)) begin
            kept = kept >> 1;
            te++;
        end
        if (te >= 128) begin
            res = tr ? {s, 31'h7F7FFFFF} : {s, 8'hFF, 23'b0};
            return {res, 3'b101};
        end
        fld = (kept >= (64'd1 << 23)) ? te + 127 : 0;
        res = {s, fld[7:0], kept[22:0]};
        return {res, 1'b0, tiny && inx, inx};
    endfunction

    function automatic logic [51:0] pattern(input int k, input int e);
        int ue, sh;
        logic [63:0] h;
        ue = e - 1023;
        sh = 29 + ((ue < -126) ? (-126 - ue) : 0);
        case (k)
            0: return '0;
            1: return '1;
            2: return 52'd1 << 28;
            3: return (52'd1 << 29) | (52'd1 << 28);
            4: return (52'd1 << 28) | 52'd1;
            5: return (52'd1 << 28) - 52'd1;
            6: return 52'd1;
            7: begin
                h = 64'(e + 1) * 64'h9E3779B97F4A7C15;
                return h[51:0];
            end
            8: return (sh - 1 < 52) ? (52'd1 << (sh - 1)) : 52'd0;
            default: return (sh < 52) ? ((52'd1 << (sh - 1)) | (52'd1 << sh)) : 52'd0;
        endcase
    endfunction

    function automatic string tag_of(input logic [63:0] d, input logic tr, input logic [34:0] ex);
        int ue;
        ue = int'(d[62:52]) - 1023;
        if (d[62:0] == 0) return "R3";
        if (ex[2]) return tr ? "R8" : "R7";
        if (ue < -126) return "R10";
        return tr ? "R6" : "R5";
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        failures++;
        $display("FAIL R11 watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [35:0] got;
        logic [34:0] ex;
        logic [63:0] d;
        logic [31:0] held;

        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", {out_valid, out_data, out_ovf, out_unf, out_inx}, 36'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", {out_valid, out_data, out_ovf, out_unf, out_inx}, 36'd0);

        // R4: exact conversions
        convert(64'h3FF0000000000000, 1'b0, got);
        check("R4", got, {1'b1, 32'h3F800000, 3'b000});
        // R11: output holds while in_valid is low
        held = out_data;
        @(negedge clk);
        in_data = 64'hFFF0000000000000;
        rnd_trunc = 1'b1;
        @(negedge clk);
        check("R11", {out_valid, out_data, out_ovf, out_unf, out_inx}, {1'b0, held, 3'b000});
        // R2: negative sign copied
        convert(64'hC000000000000000, 1'b1, got);
        check("R2", got, {1'b1, 32'hC0000000, 3'b000});
        // R3: negative zero
        convert(64'h8000000000000000, 1'b0, got);
        check("R3", got, {1'b1, 32'h80000000, 3'b000});
        // R5 / R6: pi rounds up to nearest, truncates down
        convert(64'h400921FB54442D18, 1'b0, got);
        check("R5", got, {1'b1, 32'h40490FDB, 3'b001});
        convert(64'h400921FB54442D18, 1'b1, got);
        check("R6", got, {1'b1, 32'h40490FDA, 3'b001});
        // R9: largest finite, and half an ulp above it
        convert(64'h47EFFFFFE0000000, 1'b0, got);
        check("R9", got, {1'b1, 32'h7F7FFFFF, 3'b000});
        convert(64'h47EFFFFFF0000000, 1'b0, got);
        check("R9", got, {1'b1, 32'h7F800000, 3'b101});
        convert(64'h47EFFFFFF0000000, 1'b1, got);
        check("R9", got, {1'b1, 32'h7F7FFFFF, 3'b001});
        // R7 / R8: infinity operand overflows through rounding
        convert(64'h7FF0000000000000, 1'b0, got);
        check("R7", got, {1'b1, 32'h7F800000, 3'b101});
        convert(64'hFFF0000000000000, 1'b1, got);
        check("R8", got, {1'b1, 32'hFF7FFFFF, 3'b101});
        // R10: smallest subnormal exact, half of it ties to zero
        convert(64'h36A0000000000000, 1'b0, got);
        check("R10", got, {1'b1, 32'h00000001, 3'b000});
        convert(64'h3690000000000000, 1'b0, got);
        check("R10", got, {1'b1, 32'h00000000, 3'b011});
        convert(64'h3690000000000000, 1'b1, got);
        check("R10", got, {1'b1, 32'h00000000, 3'b011});

        // sweep every exponent, with rounding-sensitive fractions and both modes
        for (int e = 0; e < 2048; e++) begin
            for (int k = 0; k < 10; k++) begin
                for (int t = 0; t < 2; t++) begin
                    d  = {1'(e ^ k), 11'(e), pattern(k, e)};
                    ex = model(d, 1'(t));
                    convert(d, 1'(t), got);
                    check(tag_of(d, 1'(t), ex), got, {1'b1, ex});
                end
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule